// File: doc/BRIEF.md
# Direct-Mapped Word Cache Controller

This block places a small direct-mapped cache between a processor port and a slower main-memory port. Each line holds exactly one memory word together with a tag, a valid bit and, when copy-back is selected, a dirty bit. The processor issues byte-addressed requests. A read returns the whole word that contains the addressed byte. A write carries one byte, which lands in the lane chosen by the low address bits.

On the memory side, only word addresses are sent. Each access is held until memory answers with a one-cycle ready pulse, after any number of wait cycles. A compile-time parameter picks the write policy. Write-through sends every write to memory and never allocates on a write miss. Copy-back keeps writes in the cache and flushes a dirty line only when another tag displaces it. Two counters record how many lookups hit and how many missed.

Top module: `dm_word_cache`

## Requirements
- R1: A byte address splits, from the top down, into tag `addr[6:3]`, line index `addr[2:1]` and byte lane `addr[0]`. The memory-side address is the word address `addr[6:1]`, so it carries no lane bit.
- R2: After reset every line is invalid, `req_ready` and `mem_valid` are low, and both counters are zero. The first access to any line is therefore a miss.
- R3: A read hits only when the indexed line is valid and its stored tag equals the request tag. A hit returns the stored word and causes no memory access.
- R4: A read miss fetches the word at its word address, returns that word, and installs it clean in the indexed line with the new tag. Whatever occupied the line before is replaced.
- R5: A write changes only one byte lane. Lane 0 (`addr[0]`=0) is bits [7:0] and lane 1 is bits [15:8]; the other lane of the word keeps its value.
- R6: With `COPY_BACK`=0, every write produces one memory write to its word address, with only the addressed lane's bit set in `mem_be` (bit n enables bits [8n+7:8n]). A write hit also updates the cached word. A write miss installs nothing.
- R7: With `COPY_BACK`=1, a write hit updates the cache, marks the line dirty and makes no memory access. A write miss fetches the word, merges the byte into it and installs the result as dirty.
- R8: With `COPY_BACK`=1, when a miss lands on a dirty line, the old word is written first to the word address built from the old tag and the index, with all byte enables set. The fetch for the new word follows.
- R9: `req_ready` is high for exactly one cycle per request. A memory request keeps `mem_valid`, `mem_we` and `mem_addr` steady until `mem_ready`.
- R10: Each request increments exactly one of `hit_count` or `miss_count`, chosen by the outcome of its tag lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present, held until `req_ready` |
| req_we | input | 1 | 1 = byte write, 0 = word read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 8*WORD_BYTES | Read word, valid with `req_ready` |
| mem_valid | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | ADDR_W-log2(WORD_BYTES) | Word address |
| mem_wdata | output | 8*WORD_BYTES | Write word |
| mem_be | output | WORD_BYTES | Byte-lane enables for writes |
| mem_ready | input | 1 | One-cycle completion from memory |
| mem_rdata | input | 8*WORD_BYTES | Read word, valid with `mem_ready` |
| hit_count | output | CNT_W | Lookups that hit |
| miss_count | output | CNT_W | Lookups that missed |

## Verification
The assertions assume that the processor holds `req_valid` and its request fields steady until the ready pulse, and drops `req_valid` right after it. They also assume that memory pulses `mem_ready` for only one cycle, and only while a request is pending. The bench's request task and memory responder behave this way: memory waits a varying 0 to 3 cycles before each answer. A behavioural model in the bench tracks line contents and memory. It predicts every memory access in order, along with each returned word and both counters. The addresses are biased to a few tags so that conflicts, dirty evictions and same-word hits all recur.

// File: rtl/cache_pkg.sv
package cache_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WBACK = 3'd1,
        ST_FILL  = 3'd2,
        ST_WTHRU = 3'd3,
        ST_DONE  = 3'd4
    } cstate_e;
endpackage

// File: rtl/cache_addr_split.sv
module cache_addr_split #(
    parameter int ADDR_W = 7,
    parameter int OFF_W  = 1,
    parameter int IDX_W  = 2,
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [TAG_W-1:0]  tag,
    output logic [IDX_W-1:0]  idx,
    output logic [OFF_W-1:0]  lane
);
    assign tag  = addr[ADDR_W-1 -: TAG_W];
    assign idx  = addr[OFF_W +: IDX_W];
    assign lane = addr[OFF_W-1:0];
endmodule

// File: rtl/cache_line_store.sv
module cache_line_store #(
    parameter int LINES  = 4,
    parameter int TAG_W  = 4,
    parameter int WORD_W = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [WORD_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              wr_dirty
);
    logic              valid_q [LINES];
    logic              valid_d [LINES];
    logic              dirty_q [LINES];
    logic              dirty_d [LINES];
    logic [TAG_W-1:0]  tag_q   [LINES];
    logic [TAG_W-1:0]  tag_d   [LINES];
    logic [WORD_W-1:0] data_q  [LINES];
    logic [WORD_W-1:0] data_d  [LINES];

    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            valid_d[i] = valid_q[i];
            dirty_d[i] = dirty_q[i];
            tag_d[i]   = tag_q[i];
            data_d[i]  = data_q[i];
        end
        if (wr_en) begin
            valid_d[wr_idx] = 1'b1;
            dirty_d[wr_idx] = wr_dirty;
            tag_d[wr_idx]   = wr_tag;
            data_d[wr_idx]  = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                valid_q[i] <= 1'b0;
                dirty_q[i] <= 1'b0;
                tag_q[i]   <= '0;
                data_q[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < LINES; i++) begin
                valid_q[i] <= valid_d[i];
                dirty_q[i] <= dirty_d[i];
                tag_q[i]   <= tag_d[i];
                data_q[i]  <= data_d[i];
            end
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = data_q[rd_idx];

    for (genvar g = 0; g < LINES; g++) begin : g_line_chk
        AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            dirty_q[g] |-> valid_q[g]);  // R7
    end
endmodule

// File: rtl/dm_word_cache.sv
module dm_word_cache #(
    parameter int ADDR_W     = 7,
    parameter int WORD_BYTES = 2,
    parameter int LINES      = 4,
    parameter bit COPY_BACK  = 1'b1,
    parameter int CNT_W      = 16,
    localparam int WORD_W  = 8 * WORD_BYTES,
    localparam int OFF_W   = $clog2(WORD_BYTES),
    localparam int IDX_W   = $clog2(LINES),
    localparam int TAG_W   = ADDR_W - IDX_W - OFF_W,
    localparam int MADDR_W = ADDR_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_we,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [7:0]         req_wdata,
    output logic               req_ready,
    output logic [WORD_W-1:0]  req_rdata,
    output logic               mem_valid,
    output logic               mem_we,
    output logic [MADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    output logic [WORD_BYTES-1:0] mem_be,
    input  logic               mem_ready,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic [CNT_W-1:0]   hit_count,
    output logic [CNT_W-1:0]   miss_count
);
    import cache_pkg::*;

    typedef struct packed {
        cstate_e               state;
        logic                  ready;
        logic [WORD_W-1:0]     rdata;
        logic                  mvalid;
        logic                  mwe;
        logic [MADDR_W-1:0]    maddr;
        logic [WORD_W-1:0]     mwdata;
        logic [WORD_BYTES-1:0] mbe;
        logic [CNT_W-1:0]      hits;
        logic [CNT_W-1:0]      misses;
    } regs_t;

    regs_t r_q, r_d;

    logic [TAG_W-1:0]  rq_tag;
    logic [IDX_W-1:0]  rq_idx;
    logic [OFF_W-1:0]  rq_lane;
    logic              ln_valid, ln_dirty;
    logic [TAG_W-1:0]  ln_tag;
    logic [WORD_W-1:0] ln_data;
    logic              st_we, st_dirty;
    logic [WORD_W-1:0] st_data;
    logic              lookup_hit;

    cache_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_split (
        .addr(req_addr), .tag(rq_tag), .idx(rq_idx), .lane(rq_lane)
    );

    cache_line_store #(.LINES(LINES), .TAG_W(TAG_W), .WORD_W(WORD_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(rq_idx), .rd_valid(ln_valid), .rd_dirty(ln_dirty),
        .rd_tag(ln_tag), .rd_data(ln_data),
        .wr_en(st_we), .wr_idx(rq_idx), .wr_tag(rq_tag),
        .wr_data(st_data), .wr_dirty(st_dirty)
    );

    function automatic logic [WORD_W-1:0] merge_lane(input logic [WORD_W-1:0] w,
                                                     input logic [OFF_W-1:0] sel,
                                                     input logic [7:0] b);
        logic [WORD_W-1:0] o;
        o = w;
        for (int l = 0; l < WORD_BYTES; l++)
            if (OFF_W'(l) == sel) o[l*8 +: 8] = b;
        return o;
    endfunction

    assign lookup_hit = ln_valid && (ln_tag == rq_tag);

    always_comb begin
        r_d      = r_q;
        r_d.ready = 1'b0;
        st_we    = 1'b0;
        st_dirty = 1'b0;
        st_data  = ln_data;
        unique case (r_q.state)
            ST_IDLE: if (req_valid) begin
                if (lookup_hit) r_d.hits   = r_q.hits + CNT_W'(1);
                else            r_d.misses = r_q.misses + CNT_W'(1);
                if (req_we && !COPY_BACK) begin
                    if (lookup_hit) begin
                        st_we   = 1'b1;
                        st_data = merge_lane(ln_data, rq_lane, req_wdata);
                    end
                    r_d.mvalid = 1'b1;
                    r_d.mwe    = 1'b1;
                    r_d.maddr  = {rq_tag, rq_idx};
                    r_d.mwdata = {WORD_BYTES{req_wdata}};
                    r_d.mbe    = WORD_BYTES'(1) << rq_lane;
                    r_d.state  = ST_WTHRU;
                end else if (lookup_hit) begin
                    if (req_we) begin
                        st_we    = 1'b1;
                        st_dirty = 1'b1;
                        st_data  = merge_lane(ln_data, rq_lane, req_wdata);
                    end
                    r_d.rdata = ln_data;
                    r_d.ready = 1'b1;
                    r_d.state = ST_DONE;
                end else if (COPY_BACK && ln_valid && ln_dirty) begin
                    r_d.mvalid = 1'b1;
                    r_d.mwe    = 1'b1;
                    r_d.maddr  = {ln_tag, rq_idx};
                    r_d.mwdata = ln_data;
                    r_d.mbe    = '1;
                    r_d.state  = ST_WBACK;
                end else begin
                    r_d.mvalid = 1'b1;
                    r_d.mwe    = 1'b0;
                    r_d.maddr  = {rq_tag, rq_idx};
                    r_d.state  = ST_FILL;
                end
            end
            ST_WBACK: if (mem_ready) begin
                r_d.mvalid = 1'b1;
                r_d.mwe    = 1'b0;
                r_d.maddr  = {rq_tag, rq_idx};
                r_d.state  = ST_FILL;
            end
            ST_FILL: if (mem_ready) begin
                r_d.mvalid = 1'b0;
                st_we      = 1'b1;
                st_dirty   = req_we;
                st_data    = req_we ? merge_lane(mem_rdata, rq_lane, req_wdata) : mem_rdata;
                r_d.rdata  = mem_rdata;
                r_d.ready  = 1'b1;
                r_d.state  = ST_DONE;
            end
            ST_WTHRU: if (mem_ready) begin
                r_d.mvalid = 1'b0;
                r_d.ready  = 1'b1;
                r_d.state  = ST_DONE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign req_ready  = r_q.ready;
    assign req_rdata  = r_q.rdata;
    assign mem_valid  = r_q.mvalid;
    assign mem_we     = r_q.mwe;
    assign mem_addr   = r_q.maddr;
    assign mem_wdata  = r_q.mwdata;
    assign mem_be     = r_q.mbe;
    assign hit_count  = r_q.hits;
    assign miss_count = r_q.misses;

    AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);  // R9
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we));  // R9
    AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.state == ST_IDLE && req_valid && !req_we && lookup_hit |=> !mem_valid);  // R3
    AST_ONE_COUNTER: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hit_count) |-> $stable(miss_count));  // R10
    AST_FILL_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.state == ST_WBACK && mem_ready |=> mem_valid && !mem_we);  // R8

    if (COPY_BACK) begin : g_cb_chk
        AST_WB_FULL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
            mem_valid && mem_we |-> &mem_be);  // R8
    end else begin : g_wt_chk
        AST_WT_SINGLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
            mem_valid && mem_we |-> $countones(mem_be) == 1);  // R6
    end
endmodule

// File: tb/tb_dm_word_cache.sv
module cache_harness #(
    parameter bit COPY_BACK = 1'b1,
    parameter int NRAND     = 150
) (
    input  logic clk,
    input  logic rst_n,
    output logic done,
    output int   n_checks,
    output int   n_fails
);
    logic        req_valid, req_we, req_ready;
    logic [6:0]  req_addr;
    logic [7:0]  req_wdata;
    logic [15:0] req_rdata;
    logic        mem_valid, mem_we, mem_ready;
    logic [5:0]  mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic [1:0]  mem_be;
    logic [15:0] hit_count, miss_count;

    dm_word_cache #(.COPY_BACK(COPY_BACK)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .req_rdata(req_rdata),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_be(mem_be), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    int d_checks = 0, d_fails = 0, r_checks = 0, r_fails = 0;
    assign n_checks = d_checks + r_checks;
    assign n_fails  = d_fails + r_fails;

    // expected memory accesses: {we, addr[5:0], be[1:0], data[15:0]}
    logic [24:0] op_q[$];
    int          op_rq[$];

    bit          m_v[4];
    bit          m_dirty[4];
    logic [3:0]  m_tag[4];
    logic [15:0] m_data[4];
    logic [15:0] exp_mem[64];
    logic [15:0] mem_arr[64];
    int          eh = 0, em = 0;

    function automatic logic [15:0] init_word(int i);
        return 16'(i * 16'h0913) ^ 16'hA55A;
    endfunction

    function automatic logic [15:0] mrg(logic [15:0] w, bit lane, logic [7:0] b);
        return lane ? {b, w[7:0]} : {w[15:8], b};
    endfunction

    function automatic string rq_name(int c);
        case (c)
            1: return "R1";
            6: return "R6";
            8: return "R8";
            default: return "R4";
        endcase
    endfunction

    task automatic dchk(bit ok, string rq, logic [31:0] act, logic [31:0] expv);
        d_checks++;
        if (!ok) begin
            d_fails++;
            $display("FAIL %s (copy_back=%0d): actual %h expected %h", rq, COPY_BACK, act, expv);
        end
    endtask

    task automatic rchk(bit ok, string rq, logic [31:0] act, logic [31:0] expv);
        r_checks++;
        if (!ok) begin
            r_fails++;
            $display("FAIL %s (copy_back=%0d): actual %h expected %h", rq, COPY_BACK, act, expv);
        end
    endtask

    // memory responder: 0..3 wait cycles, one-cycle ready
    int mseed = 7;
    int dly = 0;
    initial begin
        mem_ready = 1'b0;
        mem_rdata = '0;
        for (int i = 0; i < 64; i++) mem_arr[i] = init_word(i);
        forever begin
            @(negedge clk);
            if (mem_ready) mem_ready = 1'b0;
            else if (rst_n && mem_valid) begin
                if (dly > 0) dly--;
                else begin
                    if (op_q.size() == 0) begin
                        rchk(1'b0, "R3", {7'd0, mem_we, 18'd0, mem_addr}, 32'hFFFF_FFFF);
                    end else begin
                        logic [24:0] op;
                        string nm;
                        op = op_q.pop_front();
                        nm = rq_name(op_rq.pop_front());
                        rchk(mem_we == op[24], nm, 32'(mem_we), 32'(op[24]));
                        rchk(mem_addr == op[23:18], nm, 32'(mem_addr), 32'(op[23:18]));
                        if (op[24]) begin
                            rchk(mem_be == op[17:16], nm, 32'(mem_be), 32'(op[17:16]));
                            for (int l = 0; l < 2; l++)
                                if (op[16+l])
                                    rchk(mem_wdata[l*8 +: 8] == op[l*8 +: 8], nm,
                                         32'(mem_wdata[l*8 +: 8]), 32'(op[l*8 +: 8]));
                        end
                    end
                    if (mem_we) begin
                        for (int l = 0; l < 2; l++)
                            if (mem_be[l]) mem_arr[mem_addr][l*8 +: 8] = mem_wdata[l*8 +: 8];
                    end else mem_rdata = mem_arr[mem_addr];
                    mem_ready = 1'b1;
                    mseed = mseed * 1103515245 + 12345;
                    dly = (mseed >>> 16) & 3;
                end
            end
        end
    end

    task automatic push_op(bit we, logic [5:0] a, logic [1:0] be, logic [15:0] d, int c);
        op_q.push_back({we, a, be, d});
        op_rq.push_back(c);
    endtask

    task automatic do_req(input bit we, input logic [6:0] a, input logic [7:0] wb,
                          output logic [15:0] got);
        logic [3:0] tg;
        logic [1:0] ix;
        bit         ln;
        logic [5:0] wa;
        bit         hit;
        logic [15:0] exp_rd;
        string      rtag;
        int         guard;
        tg = a[6:3]; ix = a[2:1]; ln = a[0]; wa = a[6:1];
        hit = m_v[ix] && (m_tag[ix] == tg);
        if (hit) eh++; else em++;
        exp_rd = m_data[ix];
        rtag = "R3";
        if (we && !COPY_BACK) begin
            if (hit) m_data[ix] = mrg(m_data[ix], ln, wb);
            push_op(1'b1, wa, ln ? 2'b10 : 2'b01, {wb, wb}, 6);
            exp_mem[wa] = mrg(exp_mem[wa], ln, wb);
        end else if (hit) begin
            if (we) begin
                m_data[ix] = mrg(m_data[ix], ln, wb);
                m_dirty[ix] = 1'b1;
            end
        end else begin
            if (COPY_BACK && m_v[ix] && m_dirty[ix]) begin
                push_op(1'b1, {m_tag[ix], ix}, 2'b11, m_data[ix], 8);
                exp_mem[{m_tag[ix], ix}] = m_data[ix];
            end
            push_op(1'b0, wa, 2'b00, 16'h0, 1);
            exp_rd = exp_mem[wa];
            rtag = "R4";
            m_v[ix] = 1'b1;
            m_tag[ix] = tg;
            m_data[ix] = we ? mrg(exp_mem[wa], ln, wb) : exp_mem[wa];
            m_dirty[ix] = we;
        end
        req_we = we; req_addr = a; req_wdata = wb; req_valid = 1'b1;
        guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!req_ready && guard < 60);
        dchk(req_ready, "R9", 32'(req_ready), 32'd1);
        req_valid = 1'b0;
        got = req_rdata;
        if (!we) dchk(req_rdata == exp_rd, rtag, 32'(req_rdata), 32'(exp_rd));
        dchk(hit_count == 16'(eh), "R10", 32'(hit_count), 32'(eh));
        dchk(miss_count == 16'(em), "R10", 32'(miss_count), 32'(em));
        dchk(op_q.size() == 0, (we && COPY_BACK && hit) ? "R7" : "R3", 32'(op_q.size()), 32'd0);
        @(negedge clk);
        dchk(!req_ready, "R9", 32'(req_ready), 32'd0);
    endtask

    int seed = 11;
    initial begin
        logic [15:0] got;
        done = 1'b0;
        req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
        for (int i = 0; i < 64; i++) exp_mem[i] = init_word(i);
        for (int i = 0; i < 4; i++) begin
            m_v[i] = 1'b0; m_dirty[i] = 1'b0; m_tag[i] = '0; m_data[i] = '0;
        end
        @(negedge clk);
        // R2 reset state
        dchk(!req_ready && !mem_valid, "R2", {30'd0, req_ready, mem_valid}, 32'd0);
        dchk(hit_count == 0 && miss_count == 0, "R2", {hit_count, miss_count}, 32'd0);
        while (!rst_n) @(negedge clk);
        @(negedge clk);
        do_req(1'b0, 7'h02, 8'h00, got);               // R2 first access misses
        dchk(miss_count == 16'd1, "R2", 32'(miss_count), 32'd1);
        do_req(1'b0, 7'h03, 8'h00, got);               // R3 same word, other lane: hit
        dchk(got == init_word(1), "R3", 32'(got), 32'(init_word(1)));
        do_req(1'b1, 7'h03, 8'h5A, got);               // write lane 1
        do_req(1'b0, 7'h02, 8'h00, got);
        dchk(got == {8'h5A, init_word(1)[7:0]}, "R5", 32'(got), {16'd0, 8'h5A, init_word(1)[7:0]});
        do_req(1'b0, 7'h42, 8'h00, got);               // conflicting tag on line 1
        dchk(got == init_word(33), "R4", 32'(got), 32'(init_word(33)));
        do_req(1'b0, 7'h02, 8'h00, got);               // written byte must have reached memory
        dchk(got == {8'h5A, init_word(1)[7:0]}, "R8", 32'(got), {16'd0, 8'h5A, init_word(1)[7:0]});
        do_req(1'b1, 7'h14, 8'hC3, got);               // write miss, lane 0
        do_req(1'b0, 7'h14, 8'h00, got);
        dchk(got == {init_word(10)[15:8], 8'hC3}, COPY_BACK ? "R7" : "R6",
             32'(got), {16'd0, init_word(10)[15:8], 8'hC3});
        for (int n = 0; n < NRAND; n++) begin
            logic [6:0] a;
            seed = seed * 1103515245 + 12345;
            a = {(seed >>> 8) & 3, 1'b0, 3'd0} | 7'((seed >>> 12) & 7);
            do_req(((seed >>> 20) & 3) == 0, a, 8'((seed >>> 4) & 255), got);
        end
        done = 1'b1;
    end
endmodule

module tb_dm_word_cache;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic done_cb, done_wt;
    int   c_cb, f_cb, c_wt, f_wt;

    cache_harness #(.COPY_BACK(1'b1)) h_cb (
        .clk(clk), .rst_n(rst_n), .done(done_cb), .n_checks(c_cb), .n_fails(f_cb));
    cache_harness #(.COPY_BACK(1'b0)) h_wt (
        .clk(clk), .rst_n(rst_n), .done(done_wt), .n_checks(c_wt), .n_fails(f_wt));

    initial begin
        int cyc = 0;
        int wd = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        while (!(done_cb === 1'b1 && done_wt === 1'b1) && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (cyc >= 100000) begin
            wd = 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        end
        $display("End of test - %0d assertions evaluated, %0d failures",
                 c_cb + c_wt + wd, f_cb + f_wt + wd);
        $finish;
    end
endmodule